// File: doc/BRIEF.md
# Prioritizing Vectored Interrupt Controller

This block gathers a bank of peripheral interrupt request lines and two fixed system exception inputs: a non-maskable interrupt and a hard fault. Each source has a sticky pending flag. A pending flag is set by a low-to-high transition on its request line or by a software set pulse. For peripheral lines only, a software clear pulse drops it. The flag also drops when the core acknowledges that source. Each peripheral line has its own enable bit and a programmable priority level.

From the pending and enabled sources, the block presents one winner to the core every cycle. It outputs the winner's vector index and the address of its vector-table word, computed from a programmable table base. The vector table reserves its lowest words for the initial stack pointer, the reset handler and the two system exceptions. The peripheral entries come after those, ordered by line number. The winner is chosen by combinational logic on the registered pending state. An acknowledge therefore takes effect at the clock edge, and the next winner appears in the following cycle.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset no source is pending: `req_valid` is 0, `vec_index` is 0 and `vec_addr` equals `vtor_base`.
- R2: Vector index layout: 0 is the initial stack pointer word and 1 is the reset entry (neither is ever presented). 2 is the non-maskable interrupt, 3 is the hard fault, and peripheral line n is presented as index 4+n.
- R3: `vec_addr` always equals `vtor_base` plus four times `vec_index`. This also holds when the base changes while a source is presented.
- R4: A pending non-maskable interrupt is presented ahead of everything else, whatever the enable inputs hold. A pending hard fault is presented next, but only while `fault_en` is 1. Peripheral lines rank below both.
- R5: Among pending, enabled peripheral lines, the lowest numeric priority value in `irq_prio` wins. Line n's level sits in bits [n*PRIO_W +: PRIO_W]. On equal levels, the lower line number wins.
- R6: A peripheral line whose `irq_enable` bit is 0 is never presented, but its pending flag is kept. It is presented once re-enabled.
- R7: A pending flag is set only by a rising request line. A line held high sets it once and does not set it again after it is cleared.
- R8: A `sw_set_pend` pulse sets a peripheral pending flag and a `sw_clr_pend` pulse clears it. When a set and a clear of the same flag fall in one cycle (software clear or acknowledge), the set wins.
- R9: `ack` with `req_valid` high clears the pending flag of the presented source at that clock edge. The next winner is presented in the following cycle. `ack` with `req_valid` low has no effect.
- R10: A pending flag stays set over any number of cycles until it is cleared by software or by acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | NUM_IRQ | Peripheral request lines, one per line |
| irq_enable | input | NUM_IRQ | Per-line enable; 0 masks the line |
| irq_prio | input | NUM_IRQ*PRIO_W | Per-line priority level, lower value is more urgent |
| sw_set_pend | input | NUM_IRQ | Software set-pending pulses |
| sw_clr_pend | input | NUM_IRQ | Software clear-pending pulses |
| nmi_req | input | 1 | Non-maskable interrupt request line |
| fault_req | input | 1 | Hard fault request line |
| fault_en | input | 1 | Allows a pending hard fault to be presented |
| vtor_base | input | ADDR_W | Vector table base address |
| ack | input | 1 | Core acknowledge of the presented source |
| req_valid | output | 1 | A source is being presented |
| vec_index | output | IDX_W | Presented vector index |
| vec_addr | output | ADDR_W | Address of the presented vector word |

## Verification
Two of the block's functions can act on the same pending flag in one cycle. One case is the core acknowledging a line while that line's request rises again. The other is software pulsing set and clear of one flag together. The bench provokes both at a chosen edge. It judges them by the flag that is still pending afterwards: the source must still be presented in the next cycle, with the same index and address. A behavioural model, stepped at every edge, confirms the outcome on the same cycle.

// File: rtl/pvic_pkg.sv
package pvic_pkg;
  // Vector slots below the first peripheral entry
  localparam int SYS_SLOTS  = 4;
  localparam int SLOT_NMI   = 2;
  localparam int SLOT_FAULT = 3;

  // Vector slot of peripheral line n
  function automatic int irq_slot(input int n);
    return SYS_SLOTS + n;
  endfunction
endpackage

// File: rtl/pvic_pend_bit.sv
module pvic_pend_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic req_line,
  input  logic sw_set,
  input  logic clr,
  output logic pend
);
  logic line_q;
  logic rise;

  assign rise = req_line & ~line_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_q <= 1'b0;
      pend   <= 1'b0;
    end else begin
      line_q <= req_line;
      if (rise | sw_set) pend <= 1'b1;   // set has precedence over clear
      else if (clr)      pend <= 1'b0;
    end
  end
endmodule

// File: rtl/pvic_arb.sv
module pvic_arb #(
  parameter int NUM_IRQ = 8,
  parameter int PRIO_W  = 3,
  parameter int IRQ_W   = 3
) (
  input  logic [NUM_IRQ-1:0]        elig,
  input  logic [NUM_IRQ*PRIO_W-1:0] prio,
  output logic                      found,
  output logic [IRQ_W-1:0]          win
);
  logic [PRIO_W-1:0] best;

  // Strictly-lower comparison keeps the lower line number on ties
  always_comb begin
    found = 1'b0;
    win   = '0;
    best  = '0;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (elig[i] && (!found || prio[i*PRIO_W +: PRIO_W] < best)) begin
        found = 1'b1;
        best  = prio[i*PRIO_W +: PRIO_W];
        win   = IRQ_W'(i);
      end
    end
  end
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl #(
  parameter int NUM_IRQ = 8,
  parameter int PRIO_W  = 3,
  parameter int ADDR_W  = 32,
  localparam int IDX_W  = $clog2(pvic_pkg::SYS_SLOTS + NUM_IRQ),
  localparam int IRQ_W  = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_IRQ-1:0]        irq_req,
  input  logic [NUM_IRQ-1:0]        irq_enable,
  input  logic [NUM_IRQ*PRIO_W-1:0] irq_prio,
  input  logic [NUM_IRQ-1:0]        sw_set_pend,
  input  logic [NUM_IRQ-1:0]        sw_clr_pend,
  input  logic                      nmi_req,
  input  logic                      fault_req,
  input  logic                      fault_en,
  input  logic [ADDR_W-1:0]         vtor_base,
  input  logic                      ack,
  output logic                      req_valid,
  output logic [IDX_W-1:0]          vec_index,
  output logic [ADDR_W-1:0]         vec_addr
);
  import pvic_pkg::*;

  function automatic logic [ADDR_W-1:0] slot_address(input logic [ADDR_W-1:0] base,
                                                     input logic [IDX_W-1:0]  idx);
    return base + (ADDR_W'(idx) << 2);
  endfunction

  // Named internal events
  logic [NUM_IRQ-1:0] per_pend;
  logic [NUM_IRQ-1:0] ack_vec;
  logic               nmi_pend, fault_pend;
  logic               ack_take, ack_nmi, ack_fault;
  logic               arb_found, sel_is_periph;
  logic [IRQ_W-1:0]   arb_win;

  genvar g;
  generate
    for (g = 0; g < NUM_IRQ; g++) begin : g_line
      assign ack_vec[g] = ack_take && sel_is_periph && (arb_win == IRQ_W'(g));
      pvic_pend_bit u_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_line (irq_req[g]),
        .sw_set   (sw_set_pend[g]),
        .clr      (sw_clr_pend[g] | ack_vec[g]),
        .pend     (per_pend[g])
      );
    end
  endgenerate

  pvic_pend_bit u_nmi (
    .clk (clk), .rst_n (rst_n), .req_line (nmi_req),
    .sw_set (1'b0), .clr (ack_nmi), .pend (nmi_pend)
  );

  pvic_pend_bit u_fault (
    .clk (clk), .rst_n (rst_n), .req_line (fault_req),
    .sw_set (1'b0), .clr (ack_fault), .pend (fault_pend)
  );

  pvic_arb #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W), .IRQ_W(IRQ_W)) u_arb (
    .elig  (per_pend & irq_enable),
    .prio  (irq_prio),
    .found (arb_found),
    .win   (arb_win)
  );

  always_comb begin
    req_valid     = 1'b1;
    sel_is_periph = 1'b0;
    vec_index     = '0;
    if (nmi_pend) begin
      vec_index = IDX_W'(SLOT_NMI);
    end else if (fault_pend && fault_en) begin
      vec_index = IDX_W'(SLOT_FAULT);
    end else if (arb_found) begin
      sel_is_periph = 1'b1;
      vec_index     = IDX_W'(irq_slot(int'(arb_win)));
    end else begin
      req_valid = 1'b0;
    end
  end

  assign ack_take  = ack & req_valid;
  assign ack_nmi   = ack_take && (vec_index == IDX_W'(SLOT_NMI));
  assign ack_fault = ack_take && (vec_index == IDX_W'(SLOT_FAULT));
  assign vec_addr  = slot_address(vtor_base, vec_index);
endmodule

// File: rtl/pvic_checker.sv
module pvic_checker #(
  parameter int NUM_IRQ = 8,
  parameter int IDX_W   = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_IRQ-1:0] per_pend,
  input logic [NUM_IRQ-1:0] irq_enable,
  input logic [NUM_IRQ-1:0] sw_set_pend,
  input logic [NUM_IRQ-1:0] sw_clr_pend,
  input logic [NUM_IRQ-1:0] ack_vec,
  input logic               nmi_pend,
  input logic               fault_pend,
  input logic               fault_en,
  input logic               req_valid,
  input logic [IDX_W-1:0]   vec_index
);
  logic sel_enabled;
  logic sel_periph;

  always_comb begin
    sel_enabled = 1'b0;
    sel_periph  = 1'b0;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (vec_index == IDX_W'(pvic_pkg::irq_slot(i))) begin
        sel_enabled = irq_enable[i];
        sel_periph  = 1'b1;
      end
    end
  end

  // R4: pending NMI always presented, regardless of masks
  a_r4_nmi_first: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_pend |-> (req_valid && vec_index == IDX_W'(pvic_pkg::SLOT_NMI)));

  // R6: a masked peripheral line is never presented
  a_r6_masked_never: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && sel_periph) |-> sel_enabled);

  // R10: pending flags only drop through software clear or acknowledge
  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(per_pend) & ~$past(sw_clr_pend) & ~$past(ack_vec) & ~per_pend) == '0));

  // R8: a software set always leaves the flag pending
  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|sw_set_pend) |=> (($past(sw_set_pend) & ~per_pend) == '0));

  // R2: something is presented exactly when an eligible source is pending
  a_r2_valid_match: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid == (nmi_pend || (fault_pend && fault_en) || |(per_pend & irq_enable)));
endmodule

bind vec_irq_ctrl pvic_checker #(.NUM_IRQ(NUM_IRQ), .IDX_W(IDX_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .per_pend    (per_pend),
  .irq_enable  (irq_enable),
  .sw_set_pend (sw_set_pend),
  .sw_clr_pend (sw_clr_pend),
  .ack_vec     (ack_vec),
  .nmi_pend    (nmi_pend),
  .fault_pend  (fault_pend),
  .fault_en    (fault_en),
  .req_valid   (req_valid),
  .vec_index   (vec_index)
);

// File: tb/tb_vec_irq_ctrl.sv
module tb_vec_irq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 8;
  localparam int PW = 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [N-1:0]  irq_req, irq_enable, sw_set_pend, sw_clr_pend;
  logic [N*PW-1:0] irq_prio;
  logic          nmi_req, fault_req, fault_en, ack;
  logic [31:0]   vtor_base;
  logic          req_valid;
  logic [3:0]    vec_index;
  logic [31:0]   vec_addr;

  int checks = 0;
  int errors = 0;
  string cur_tag = "R1";

  // Behavioural reference state
  bit mp[N];
  bit mprev[N];
  bit mnmi, mfault, mprev_nmi, mprev_fault;

  always #(CLK_PERIOD/2) clk = ~clk;

  vec_irq_ctrl dut (
    .clk (clk), .rst_n (rst_n), .irq_req (irq_req), .irq_enable (irq_enable),
    .irq_prio (irq_prio), .sw_set_pend (sw_set_pend), .sw_clr_pend (sw_clr_pend),
    .nmi_req (nmi_req), .fault_req (fault_req), .fault_en (fault_en),
    .vtor_base (vtor_base), .ack (ack), .req_valid (req_valid),
    .vec_index (vec_index), .vec_addr (vec_addr)
  );

  // Scan priority levels from most urgent, lines from lowest number
  function automatic int m_sel();
    if (mnmi) return 2;
    if (mfault && fault_en) return 3;
    for (int lvl = 0; lvl < (1 << PW); lvl++)
      for (int i = 0; i < N; i++)
        if (mp[i] && irq_enable[i] && int'(irq_prio[i*PW +: PW]) == lvl) return 4 + i;
    return -1;
  endfunction

  task automatic check(string tag, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare_model();
    int e;
    int ei;
    e  = m_sel();
    ei = (e < 0) ? 0 : e;
    check(cur_tag, int'(req_valid), (e >= 0) ? 1 : 0, "model valid");
    check(cur_tag, int'(vec_index), ei, "model index");
    check(cur_tag, int'(vec_addr), int'(vtor_base + 32'(ei * 4)), "model addr");
  endtask

  // Inputs are set before the call (at a falling edge)
  task automatic tick();
    int s;
    bit set, clr;
    s = m_sel();
    @(posedge clk);
    for (int i = 0; i < N; i++) begin
      set = (irq_req[i] && !mprev[i]) || sw_set_pend[i];
      clr = sw_clr_pend[i] || (ack && s == 4 + i);
      if (set) mp[i] = 1'b1; else if (clr) mp[i] = 1'b0;
      mprev[i] = irq_req[i];
    end
    set = nmi_req && !mprev_nmi;
    clr = ack && s == 2;
    if (set) mnmi = 1'b1; else if (clr) mnmi = 1'b0;
    mprev_nmi = nmi_req;
    set = fault_req && !mprev_fault;
    clr = ack && s == 3;
    if (set) mfault = 1'b1; else if (clr) mfault = 1'b0;
    mprev_fault = fault_req;
    @(negedge clk);
    compare_model();
    sw_set_pend = '0;
    sw_clr_pend = '0;
    ack = 1'b0;
  endtask

  // Directed expectation with literal values from the requirements
  task automatic expect_out(string tag, bit v, int idx);
    check(tag, int'(req_valid), int'(v), "valid");
    check(tag, int'(vec_index), idx, "index");
    check(tag, int'(vec_addr), int'(vtor_base + 32'(idx * 4)), "addr");
  endtask

  task automatic set_prio(int line, int p);
    irq_prio[line*PW +: PW] = PW'(p);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    irq_req = '0; irq_enable = '1; sw_set_pend = '0; sw_clr_pend = '0;
    nmi_req = 1'b0; fault_req = 1'b0; fault_en = 1'b1; ack = 1'b0;
    vtor_base = 32'h0000_2000;
    for (int i = 0; i < N; i++) begin
      irq_prio[i*PW +: PW] = 3'd4;
      mp[i] = 1'b0;
      mprev[i] = 1'b0;
    end
    mnmi = 0; mfault = 0; mprev_nmi = 0; mprev_fault = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    cur_tag = "R1";
    expect_out("R1", 1'b0, 0);

    // R7 rising line, R2 slot layout, R3 address
    cur_tag = "R7";
    set_prio(3, 5);
    irq_req[3] = 1'b1;
    tick();
    expect_out("R2", 1'b1, 7);
    check("R3", int'(vec_addr), 32'h201C, "addr literal");
    tick();
    expect_out("R10", 1'b1, 7);

    // R9 acknowledge, R7 held line does not re-set
    cur_tag = "R9";
    ack = 1'b1;
    tick();
    expect_out("R9", 1'b0, 0);
    tick();
    expect_out("R7", 1'b0, 0);
    irq_req[3] = 1'b0;
    ack = 1'b1;                // R9 ack with nothing valid has no effect
    tick();
    expect_out("R9", 1'b0, 0);

    // R5 equal levels then distinct levels
    cur_tag = "R5";
    set_prio(2, 2);
    set_prio(5, 2);
    sw_set_pend = 8'b0010_0100;
    tick();
    expect_out("R5", 1'b1, 6);
    set_prio(5, 1);
    tick();
    expect_out("R5", 1'b1, 9);

    // R6 masking keeps pending
    cur_tag = "R6";
    irq_enable[5] = 1'b0;
    tick();
    expect_out("R6", 1'b1, 6);
    irq_enable[2] = 1'b0;
    tick();
    expect_out("R6", 1'b0, 0);
    repeat (3) tick();
    irq_enable = '1;
    tick();
    expect_out("R6", 1'b1, 9);

    // R4 system exceptions
    cur_tag = "R4";
    nmi_req = 1'b1;
    irq_enable = '0;
    tick();
    expect_out("R4", 1'b1, 2);
    fault_req = 1'b1;
    tick();
    expect_out("R4", 1'b1, 2);
    ack = 1'b1;
    tick();
    expect_out("R4", 1'b1, 3);
    fault_en = 1'b0;
    tick();
    expect_out("R4", 1'b0, 0);
    fault_en = 1'b1;
    irq_enable = '1;
    tick();
    expect_out("R4", 1'b1, 3);
    ack = 1'b1;
    tick();
    expect_out("R9", 1'b1, 9);
    ack = 1'b1;
    tick();
    expect_out("R9", 1'b1, 6);
    ack = 1'b1;
    tick();
    expect_out("R9", 1'b0, 0);
    nmi_req = 1'b0;
    fault_req = 1'b0;
    tick();

    // R8 set and clear together, then clear alone
    cur_tag = "R8";
    sw_set_pend[1] = 1'b1;
    sw_clr_pend[1] = 1'b1;
    tick();
    expect_out("R8", 1'b1, 5);
    sw_clr_pend[1] = 1'b1;
    tick();
    expect_out("R8", 1'b0, 0);

    // R8/R9 acknowledge while the same line rises again
    sw_set_pend[0] = 1'b1;
    tick();
    expect_out("R8", 1'b1, 4);
    ack = 1'b1;
    irq_req[0] = 1'b1;
    tick();
    expect_out("R8", 1'b1, 4);
    ack = 1'b1;
    tick();
    expect_out("R9", 1'b0, 0);
    irq_req[0] = 1'b0;
    tick();

    // R5 tie at the most urgent level, R3 base change
    cur_tag = "R5";
    set_prio(6, 0);
    set_prio(7, 0);
    sw_set_pend = 8'b1100_0000;
    tick();
    expect_out("R5", 1'b1, 10);
    ack = 1'b1;
    tick();
    expect_out("R5", 1'b1, 11);
    cur_tag = "R3";
    vtor_base = 32'h1000_0100;
    tick();
    expect_out("R3", 1'b1, 11);
    check("R3", int'(vec_addr), 32'h1000_012C, "addr literal");
    ack = 1'b1;
    tick();
    expect_out("R3", 1'b0, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule